// File: doc/BRIEF.md
# Coin-to-Credit Accounting Unit

This block converts coin pulses arriving on two coin chutes into game credits. Each chute has a 4-bit pricing setting that chooses between single-coin prices (one coin buys one to nine credits) and multi-coin prices (two or three coins buy credits). For the multi-coin prices the block keeps a partial-coin state for each chute. An option lets the second chute use the first chute's pricing instead of its own.

The credit count is bounded by a 4-bit maximum. A maximum of zero selects free play. A game-start pulse consumes one credit when one is available and reports whether the start was granted. Every coin is also counted in a per-chute bookkeeping counter, whether or not it produced credit. Coin switch debounce, non-volatile storage and the coin mechanism itself are handled outside this block.

All inputs are sampled on the rising clock edge. Coin and start inputs are pulses of one clock cycle, and each chute accepts at most one coin per cycle.

Top module: `coin_credit_unit`

## Requirements
- R1: With an effective setting of 0 to 8, each coin adds setting+1 credits in the cycle after the pulse.
- R2: With a setting of 9 to 13, the first coin adds nothing and the second coin adds setting-8 credits. After the second coin the chute is back at the first-coin state.
- R3: With setting 14, a first coin adds 1 credit and the following coin adds 2 credits. The chute then returns to the first-coin state.
- R4: With setting 14, a granted game start while a chute is waiting for its second coin resets that chute, so the next coin adds 1 credit. This also applies when the start and the coin arrive in the same cycle.
- R5: With setting 15, the first and second coins add nothing and the third coin adds 1 credit.
- R6: After an edge, the credit count never exceeds the maximum sampled at that edge. Credits that would pass the maximum are lost, and a lower maximum cuts the count at the next edge.
- R7: With a maximum of 0 (free play), every start pulse is granted and the credit count is held at 0.
- R8: Outside free play, a start pulse is granted (start_grant high in the same cycle) only when credits are non-zero, and a granted start takes one credit. A refused start leaves the count unchanged.
- R9: When b_follows_a is 1, chute B is priced with price_a. When it is 0, chute B uses price_b.
- R10: Each coin pulse adds 1 to that chute's bookkeeping counter, modulo 2^CNT_W. This happens even when no credit is added because of saturation or free play.
- R11: Any change to a chute's effective setting clears that chute's partial-coin state. A coin in the same cycle as the change is treated as a first coin.
- R12: After reset, the credits and both bookkeeping counters are 0, and no chute holds a partial coin.
- R13: When a start and coins arrive in the same cycle, the start is taken first, the awards are added next, and the result is clamped to the maximum.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| coin_pulse | input | 2 | One-cycle coin pulses; bit 0 is chute A, bit 1 is chute B |
| start_pulse | input | 1 | One-cycle game-start request |
| price_a | input | 4 | Pricing setting of chute A |
| price_b | input | 4 | Pricing setting of chute B |
| b_follows_a | input | 1 | Chute B uses price_a when 1 |
| max_credit | input | CRED_W | Credit ceiling; 0 selects free play |
| start_grant | output | 1 | Start request accepted this cycle |
| credits | output | CRED_W | Current credit count |
| coins_a | output | CNT_W | Coins received on chute A |
| coins_b | output | CNT_W | Coins received on chute B |

## Verification
A wrong partial-coin state is not visible at once. It shows on the next coin of that chute, as a credit jump of the wrong size (or a missing jump) one edge after that coin. For this reason the tests feed multi-coin sequences and interleave starts, setting changes and option toggles before the coin that exposes the state. A wrong credit or counter update appears one edge after its pulse. A wrong grant decision appears in the same cycle as the start pulse.

// File: rtl/coin_pkg.sv
// Shared pricing constants and types for the coin-to-credit unit.
// Assumes pricing settings are 4 bits wide; the code values below are behavioural.
package coin_pkg;
    localparam int PRICE_W = 4;
    localparam int AWARD_W = 4;   // largest single award is 9
    localparam int PART_W  = 2;   // partial-coin count up to 2

    typedef logic [PRICE_W-1:0] price_t;
    typedef logic [AWARD_W-1:0] award_t;
    typedef logic [PART_W-1:0]  part_t;

    localparam price_t SET_SINGLE_MAX = 4'd8;
    localparam price_t SET_PAIR_MAX   = 4'd13;
    localparam price_t SET_ALT        = 4'd14;
    localparam price_t SET_TRIPLE     = 4'd15;
    localparam price_t PAIR_BASE      = 4'd8;
endpackage

// File: rtl/coin_pricer.sv
// Per-chute pricer: turns a coin pulse into a credit award under one setting.
// Assumes coin is a one-cycle pulse; game_started is a start granted this cycle.
module coin_pricer
    import coin_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   coin,
    input  logic   game_started,
    input  price_t price,
    output award_t award
);
    part_t  part_q, part_d, base;
    price_t last_price_q;

    // Compute effective partial state, award and next partial state.
    always_comb begin
        if (price != last_price_q || (price == SET_ALT && game_started))
            base = '0;
        else
            base = part_q;
        award  = '0;
        part_d = base;
        if (coin) begin
            if (price <= SET_SINGLE_MAX) begin
                award = price + award_t'(1);
            end else if (price <= SET_PAIR_MAX) begin
                if (base == '0) begin
                    part_d = part_t'(1);
                end else begin
                    award  = price - PAIR_BASE;
                    part_d = '0;
                end
            end else if (price == SET_ALT) begin
                if (base == '0) begin
                    award  = award_t'(1);
                    part_d = part_t'(1);
                end else begin
                    award  = award_t'(2);
                    part_d = '0;
                end
            end else begin
                if (base == part_t'(2)) begin
                    award  = award_t'(1);
                    part_d = '0;
                end else begin
                    part_d = base + part_t'(1);
                end
            end
        end
    end

    // Hold partial-coin count and the setting it belongs to.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            part_q       <= '0;
            last_price_q <= '0;
        end else begin
            part_q       <= part_d;
            last_price_q <= price;
        end
    end
endmodule

// File: rtl/coin_tally.sv
// Bookkeeping counter: counts every coin pulse on one chute, wrapping at 2^CNT_W.
// Assumes at most one coin per cycle.
module coin_tally #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             coin,
    output logic [CNT_W-1:0] count
);
    // Advance the tally on each coin.
    always_ff @(posedge clk) begin
        if (!rst_n)    count <= '0;
        else if (coin) count <= count + 1'b1;
    end
endmodule

// File: rtl/credit_store.sv
// Credit register: applies start take, then awards, then clamps to the ceiling.
// Assumes a ceiling of zero means free play, where starts are always granted.
module credit_store
    import coin_pkg::*;
#(
    parameter int CRED_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_pulse,
    input  award_t            award_a,
    input  award_t            award_b,
    input  logic [CRED_W-1:0] max_credit,
    output logic              start_grant,
    output logic [CRED_W-1:0] credits
);
    localparam int SUM_W = ((CRED_W > AWARD_W) ? CRED_W : AWARD_W) + 2;

    logic             free_play;
    logic             take;
    logic [SUM_W-1:0] sum;

    // Decide grant and compute the next unclamped count.
    always_comb begin
        free_play   = (max_credit == '0);
        take        = start_pulse && !free_play && (credits != '0);
        start_grant = start_pulse && (free_play || credits != '0);
        sum = SUM_W'(credits) - SUM_W'(take) + SUM_W'(award_a) + SUM_W'(award_b);
    end

    // Register the count clamped to the ceiling.
    always_ff @(posedge clk) begin
        if (!rst_n)                          credits <= '0;
        else if (sum > SUM_W'(max_credit))   credits <= max_credit;
        else                                 credits <= sum[CRED_W-1:0];
    end
endmodule

// File: rtl/coin_credit_unit.sv
// Top: two chute pricers, two bookkeeping tallies and the credit register.
// Assumes one-cycle coin and start pulses, synchronous to clk.
module coin_credit_unit
    import coin_pkg::*;
#(
    parameter int CRED_W = 4,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        coin_pulse,
    input  logic              start_pulse,
    input  logic [3:0]        price_a,
    input  logic [3:0]        price_b,
    input  logic              b_follows_a,
    input  logic [CRED_W-1:0] max_credit,
    output logic              start_grant,
    output logic [CRED_W-1:0] credits,
    output logic [CNT_W-1:0]  coins_a,
    output logic [CNT_W-1:0]  coins_b
);
    localparam int NCHUTE = 2;

    price_t             eff_price [NCHUTE];
    award_t             award     [NCHUTE];
    logic [CNT_W-1:0]   tally     [NCHUTE];

    // Select each chute's effective pricing setting.
    always_comb begin
        eff_price[0] = price_a;
        eff_price[1] = b_follows_a ? price_a : price_b;
    end

    for (genvar g = 0; g < NCHUTE; g++) begin : g_chute
        coin_pricer u_pricer (
            .clk         (clk),
            .rst_n       (rst_n),
            .coin        (coin_pulse[g]),
            .game_started(start_grant),
            .price       (eff_price[g]),
            .award       (award[g])
        );
        coin_tally #(.CNT_W(CNT_W)) u_tally (
            .clk  (clk),
            .rst_n(rst_n),
            .coin (coin_pulse[g]),
            .count(tally[g])
        );
    end

    credit_store #(.CRED_W(CRED_W)) u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_pulse(start_pulse),
        .award_a    (award[0]),
        .award_b    (award[1]),
        .max_credit (max_credit),
        .start_grant(start_grant),
        .credits    (credits)
    );

    assign coins_a = tally[0];
    assign coins_b = tally[1];
endmodule

// File: rtl/coin_credit_unit_chk.sv
// Checker for the coin-to-credit unit, observing its ports only.
module coin_credit_unit_chk #(
    parameter int CRED_W = 4,
    parameter int CNT_W  = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic [1:0]        coin_pulse,
    input logic              start_pulse,
    input logic [CRED_W-1:0] max_credit,
    input logic              start_grant,
    input logic [CRED_W-1:0] credits,
    input logic [CNT_W-1:0]  coins_a,
    input logic [CNT_W-1:0]  coins_b
);
    // R6
    ceiling_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> credits <= $past(max_credit));

    // R7
    free_play_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        max_credit == '0 |=> credits == '0);

    // R7
    free_play_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start_pulse && max_credit == '0) |-> start_grant);

    // R8
    refuse_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start_pulse && max_credit != '0 && credits == '0) |-> !start_grant);

    // R8
    take_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start_grant && max_credit != '0 && coin_pulse == 2'b00) |=> credits == $past(credits) - 1'b1);

    // R8
    grant_needs_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !start_pulse |-> !start_grant);

    // R10
    tally_a_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        coin_pulse[0] |=> coins_a == $past(coins_a) + 1'b1);

    // R10
    tally_b_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        coin_pulse[1] |=> coins_b == $past(coins_b) + 1'b1);

    // R10
    tally_a_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !coin_pulse[0] |=> $stable(coins_a));

    // R10
    tally_b_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !coin_pulse[1] |=> $stable(coins_b));
endmodule

bind coin_credit_unit coin_credit_unit_chk #(.CRED_W(CRED_W), .CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .coin_pulse (coin_pulse),
    .start_pulse(start_pulse),
    .max_credit (max_credit),
    .start_grant(start_grant),
    .credits    (credits),
    .coins_a    (coins_a),
    .coins_b    (coins_b)
);

// File: tb/coin_credit_unit_tb.sv
module coin_credit_unit_tb;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [1:0]  coin_pulse;
    logic        start_pulse;
    logic [3:0]  price_a, price_b;
    logic        b_follows_a;
    logic [3:0]  max_credit;
    logic        start_grant;
    logic [3:0]  credits;
    logic [15:0] coins_a, coins_b;

    int checks = 0;
    int errors = 0;
    logic got_grant;

    always #5 clk = ~clk;

    coin_credit_unit u_dut (
        .clk(clk), .rst_n(rst_n), .coin_pulse(coin_pulse), .start_pulse(start_pulse),
        .price_a(price_a), .price_b(price_b), .b_follows_a(b_follows_a),
        .max_credit(max_credit), .start_grant(start_grant), .credits(credits),
        .coins_a(coins_a), .coins_b(coins_b)
    );

    // Vector: {setting[15:12], coins on chute A[11:8], expected credits[7:0]}, ceiling 15.
    localparam int NV = 15;
    localparam logic [15:0] VEC [NV] = '{
        {4'd0,  4'd1, 8'd1},  {4'd8,  4'd1, 8'd9},  {4'd8,  4'd2, 8'd15},
        {4'd9,  4'd1, 8'd0},  {4'd9,  4'd2, 8'd1},  {4'd13, 4'd2, 8'd5},
        {4'd13, 4'd4, 8'd10}, {4'd14, 4'd1, 8'd1},  {4'd14, 4'd2, 8'd3},
        {4'd14, 4'd3, 8'd4},  {4'd15, 4'd2, 8'd0},  {4'd15, 4'd3, 8'd1},
        {4'd15, 4'd6, 8'd2},  {4'd4,  4'd3, 8'd15}, {4'd11, 4'd3, 8'd3}
    };

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; coin_pulse = 2'b00; start_pulse = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic coin(input logic [1:0] m);
        @(negedge clk); coin_pulse = m;
        @(negedge clk); coin_pulse = 2'b00;
    endtask

    task automatic start();
        @(negedge clk); start_pulse = 1'b1;
        #1 got_grant = start_grant;
        @(negedge clk); start_pulse = 1'b0;
    endtask

    initial begin
        #1_000_000;
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        rst_n = 1'b0; coin_pulse = 2'b00; start_pulse = 1'b0;
        price_a = 4'd0; price_b = 4'd0; b_follows_a = 1'b0; max_credit = 4'd15;
        do_reset();
        check("R12 credits", credits, 0);
        check("R12 coins_a", coins_a, 0);
        check("R12 coins_b", coins_b, 0);

        // Table walk: R1, R2, R3, R5, R6 (saturation), R10 (counted at limit)
        for (int i = 0; i < NV; i++) begin
            price_a = VEC[i][15:12];
            do_reset();
            for (int k = 0; k < int'(VEC[i][11:8]); k++) coin(2'b01);
            check($sformatf("R1/R2/R3/R5/R6 set=%0d n=%0d", VEC[i][15:12], VEC[i][11:8]),
                  credits, int'(VEC[i][7:0]));
            check("R10 coins_a", coins_a, int'(VEC[i][11:8]));
        end

        // R4: setting 14, granted start between coins
        price_a = 4'd14; do_reset();
        coin(2'b01);
        start();
        check("R4 grant", got_grant, 1);
        check("R4 after start", credits, 0);
        coin(2'b01);
        check("R4 new first coin", credits, 1);
        coin(2'b01);
        check("R4 second coin", credits, 3);

        // R11: setting change clears partial coin
        price_a = 4'd9; do_reset();
        coin(2'b01);
        @(negedge clk); price_a = 4'd10;
        coin(2'b01);
        check("R11 first after change", credits, 0);
        coin(2'b01);
        check("R11 second after change", credits, 2);

        // R8: refused start at zero credits
        price_a = 4'd0; do_reset();
        start();
        check("R8 refused grant", got_grant, 0);
        check("R8 refused credits", credits, 0);
        coin(2'b01); coin(2'b01);
        start();
        check("R8 granted", got_grant, 1);
        check("R8 take one", credits, 1);

        // R13: start and coin same cycle (setting 0, credits 1)
        @(negedge clk); start_pulse = 1'b1; coin_pulse = 2'b01;
        @(negedge clk); start_pulse = 1'b0; coin_pulse = 2'b00;
        check("R13 take then add", credits, 1);

        // R6: lowering the ceiling cuts the count
        price_a = 4'd8; do_reset();
        coin(2'b01);
        check("R6 pre", credits, 9);
        @(negedge clk); max_credit = 4'd5;
        @(negedge clk);
        check("R6 lowered ceiling", credits, 5);
        max_credit = 4'd15;

        // R9: chute B own pricing, then following chute A
        price_a = 4'd2; price_b = 4'd0; b_follows_a = 1'b0; do_reset();
        coin(2'b10);
        check("R9 own pricing", credits, 1);
        @(negedge clk); b_follows_a = 1'b1;
        coin(2'b10);
        check("R9 follows A", credits, 4);
        check("R10 coins_b", coins_b, 2);
        check("R10 coins_a untouched", coins_a, 0);
        b_follows_a = 1'b0;

        // R10: both chutes in one cycle
        price_a = 4'd0; price_b = 4'd1; do_reset();
        coin(2'b11);
        check("R10 both chutes credits", credits, 3);
        check("R10 both coins_a", coins_a, 1);
        check("R10 both coins_b", coins_b, 1);

        // R7: free play
        max_credit = 4'd0; do_reset();
        coin(2'b01);
        check("R7 credits held", credits, 0);
        check("R7 coin still counted (R10)", coins_a, 1);
        start();
        check("R7 grant", got_grant, 1);
        check("R7 credits after start", credits, 0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule